// File: doc/BRIEF.md
# Serial Burst-Correcting Check-Code Unit

This unit protects a serial data field with a 32-bit cyclic check code. A start pulse opens an operation and a mode bit picks writing or reading. In write mode the field bits enter one per accepted input transfer. When the field-end strobe arrives, the unit sends the 32-bit remainder out on its output stream, most significant bit first. The remainder is computed with the generator x^32+x^23+x^21+x^11+x^2+1 from an all-zero preset. In read mode the unit takes the data field, then the field-end strobe, then 32 received check bits. It divides the whole received sequence by the generator. A zero remainder means the sector is clean.

A nonzero remainder means the transfer is stopped and no further bits are accepted. The unit then searches for a correctable burst by stepping the remainder backward one bit per cycle. The search ends when bits 31..11 of the remainder are all zero. The step count at that point gives the burst location and the low 11 bits give its pattern. If no step within the codeword length works, the error is declared hard. Buffering the sector and applying the fix to memory belong to the surrounding logic.

Both bit streams use valid/ready. A bit moves only on a clock edge where valid and ready are both high. The sender must hold valid and the bit until that edge. On the output side, the unit holds `out_valid` and `out_bit` steady while `out_ready` is low. The control and status pins are plain levels or single-cycle pulses.

Top module: `bec_unit`

## Requirements
- R1: After reset, `flag_rdy` is 1, `flag_dck`, `flag_cerr` and `flag_hard` are 0, and both `in_ready` and `out_valid` are 0.
- R2: In write mode, after the field-end strobe the unit offers exactly 32 bits on the output stream. They are the remainder of (data·x^32) mod the generator, from a zero preset, sent MSB first. The first data bit is the highest-degree coefficient.
- R3: A read whose data and check bits form a valid codeword ends with only `flag_rdy` set, and with `err_pos` and `err_pat` at 0.
- R4: A read whose error pattern lies within an 11-bit span ends with `flag_dck`, `flag_cerr` and `flag_rdy` set and `flag_hard` clear.
- R5: Codeword bit degrees count back from the last check bit, which is degree 0. Let h be the degree of the earliest erroneous bit. Then a correctable result gives `err_pos` = max(0, h-10), and bit m of `err_pat` is 1 exactly when degree `err_pos`+m is in error.
- R6: A read whose errors span more than 11 bits ends with `flag_hard`, `flag_dck`, `flag_cerr` and `flag_rdy` all set, and with `err_pos` and `err_pat` at 0.
- R7: Once a read or write has finished, `in_ready` stays 0 and incoming valid bits are ignored until the next start. The flags and result stay unchanged.
- R8: A start pulse clears all four flags, the position and the pattern in the next cycle. `flag_rdy` stays 0 until the operation ends.
- R9: The input stream is valid/ready. Idle cycles with `in_valid` low add nothing to the field. While `out_ready` is low, `out_valid` and `out_bit` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens an operation |
| mode_rd | input | 1 | Sampled with start: 1 selects read, 0 selects write |
| field_end | input | 1 | Strobe that closes the data field |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Serial input bit (data, then check bits on read) |
| in_ready | output | 1 | Unit accepts an input bit |
| out_valid | output | 1 | Check bit offered on write |
| out_bit | output | 1 | Serial check bit, MSB first |
| out_ready | input | 1 | Receiver accepts the check bit |
| flag_rdy | output | 1 | Operation finished |
| flag_dck | output | 1 | Data check error seen |
| flag_cerr | output | 1 | Controller error summary |
| flag_hard | output | 1 | Error could not be corrected |
| err_pos | output | 16 | Degree of the pattern's bit 0 |
| err_pat | output | 11 | Burst pattern, bit 10 is the earliest bit |

## Verification
Write runs use two field lengths. Out-ready is held high in one and toggled in the other, which separates the remainder value from the hold rule under back-pressure. Read runs cover four cases: a clean codeword with input gaps, a single flipped data bit, an 11-bit-wide three-bit burst, and a burst inside the check field near degree 0. These tell the clean path, the search location, the full-width pattern and the clamp of the position at zero apart. A pair of flips 12 bits apart forces the hard outcome. Extra valid bits after completion and a restart after a hard result check the halt and the clearing.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int CW = 32;
  localparam int BW = 11;
  // generator without x^32 term: x^23+x^21+x^11+x^2+1
  localparam logic [CW-1:0] GEN_LOW = 32'h00A0_0805;
  // division by x modulo the generator (x^32 term folds to bit 31)
  localparam logic [CW-1:0] GEN_REV = {1'b1, GEN_LOW[CW-1:1]};

  typedef enum logic [2:0] {
    OP_HOLD, OP_CLR, OP_ENC, OP_DIV, OP_REV, OP_SHL
  } op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_CHECK, S_EMIT, S_TEST, S_SEARCH, S_DONE
  } st_t;
endpackage

// File: rtl/bec_lfsr.sv
module bec_lfsr
  import bec_pkg::*;
#(
  parameter int CW = bec_pkg::CW,
  parameter logic [CW-1:0] GEN_F = bec_pkg::GEN_LOW,
  parameter logic [CW-1:0] GEN_B = bec_pkg::GEN_REV
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_t           op,
  input  logic          din,
  output logic [CW-1:0] syn
);
  logic [CW-1:0] r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else begin
      case (op)
        OP_CLR: r_q <= '0;
        OP_ENC: r_q <= {r_q[CW-2:0], 1'b0} ^ ((din ^ r_q[CW-1]) ? GEN_F : '0);
        OP_DIV: r_q <= {r_q[CW-2:0], din} ^ (r_q[CW-1] ? GEN_F : '0);
        OP_REV: r_q <= {1'b0, r_q[CW-1:1]} ^ (r_q[0] ? GEN_B : '0);
        OP_SHL: r_q <= {r_q[CW-2:0], 1'b0};
        default: r_q <= r_q;
      endcase
    end
  end

  assign syn = r_q;

  // backward stepping is invertible: a nonzero syndrome never collapses (R6 search)
  p_rev_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_REV && r_q != '0) |=> (r_q != '0));
endmodule

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
#(
  parameter int CW    = bec_pkg::CW,
  parameter int BW    = bec_pkg::BW,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_rd,
  input  logic             field_end,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [CW-1:0]    syn,
  output logic             in_ready,
  output logic             out_valid,
  output op_t              op,
  output logic             flag_rdy,
  output logic             flag_dck,
  output logic             flag_cerr,
  output logic             flag_hard,
  output logic [LEN_W-1:0] err_pos,
  output logic [BW-1:0]    err_pat
);
  localparam logic [LEN_W-1:0] CW_LAST = LEN_W'(CW - 1);

  st_t              st_q;
  logic             rd_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             in_fire, out_fire, found, last_k;

  assign in_ready  = (st_q == S_DATA) || (st_q == S_CHECK);
  assign out_valid = (st_q == S_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign found     = (syn[CW-1:BW] == '0);
  assign last_k    = (cnt_q == len_q + CW_LAST);

  always_comb begin
    op = OP_HOLD;
    if (start) op = OP_CLR;
    else begin
      case (st_q)
        S_DATA:   if (in_fire) op = rd_q ? OP_DIV : OP_ENC;
        S_CHECK:  if (in_fire) op = OP_DIV;
        S_EMIT:   if (out_fire) op = OP_SHL;
        S_SEARCH: if (!found && !last_k) op = OP_REV;
        default:  op = OP_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; rd_q <= 1'b0; len_q <= '0; cnt_q <= '0;
      flag_rdy <= 1'b1; flag_dck <= 1'b0; flag_cerr <= 1'b0; flag_hard <= 1'b0;
      err_pos <= '0; err_pat <= '0;
    end else if (start) begin
      st_q <= S_DATA; rd_q <= mode_rd; len_q <= '0; cnt_q <= '0;
      flag_rdy <= 1'b0; flag_dck <= 1'b0; flag_cerr <= 1'b0; flag_hard <= 1'b0;
      err_pos <= '0; err_pat <= '0;
    end else begin
      case (st_q)
        S_DATA: begin
          if (in_fire) len_q <= len_q + 1'b1;
          if (field_end) begin
            st_q  <= rd_q ? S_CHECK : S_EMIT;
            cnt_q <= '0;
          end
        end
        S_CHECK: if (in_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW_LAST) st_q <= S_TEST;
        end
        S_EMIT: if (out_fire) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW_LAST) begin
            st_q <= S_DONE; flag_rdy <= 1'b1;
          end
        end
        S_TEST: begin
          cnt_q <= '0;
          if (syn == '0) begin
            st_q <= S_DONE; flag_rdy <= 1'b1;
          end else st_q <= S_SEARCH;
        end
        S_SEARCH: begin
          if (found) begin
            err_pos <= cnt_q; err_pat <= syn[BW-1:0];
            flag_dck <= 1'b1; flag_cerr <= 1'b1; flag_rdy <= 1'b1;
            st_q <= S_DONE;
          end else if (last_k) begin
            flag_hard <= 1'b1; flag_dck <= 1'b1; flag_cerr <= 1'b1; flag_rdy <= 1'b1;
            st_q <= S_DONE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  // a finished operation accepts nothing and offers nothing (R7)
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rdy |-> (!in_ready && !out_valid));
  // a start wipes the status in the next cycle (R8)
  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!flag_rdy && !flag_dck && !flag_hard && err_pat == '0));
  // a located burst lies inside the codeword (R5)
  p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_dck && !flag_hard) |-> (err_pos <= len_q + CW_LAST));
endmodule

// File: rtl/bec_unit.sv
module bec_unit
  import bec_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_rd,
  input  logic             field_end,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_bit,
  input  logic             out_ready,
  output logic             flag_rdy,
  output logic             flag_dck,
  output logic             flag_cerr,
  output logic             flag_hard,
  output logic [LEN_W-1:0] err_pos,
  output logic [BW-1:0]    err_pat
);
  op_t           op;
  logic [CW-1:0] syn;

  bec_lfsr #(.CW(CW), .GEN_F(GEN_LOW), .GEN_B(GEN_REV)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .op(op), .din(in_bit), .syn(syn)
  );

  bec_ctrl #(.CW(CW), .BW(BW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_rd(mode_rd),
    .field_end(field_end), .in_valid(in_valid), .out_ready(out_ready),
    .syn(syn), .in_ready(in_ready), .out_valid(out_valid), .op(op),
    .flag_rdy(flag_rdy), .flag_dck(flag_dck), .flag_cerr(flag_cerr),
    .flag_hard(flag_hard), .err_pos(err_pos), .err_pat(err_pat)
  );

  assign out_bit = syn[CW-1];

  // streams never run together (R2)
  p_io_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // back-pressure holds the offered check bit (R9)
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_bit)));
  // hard implies the full flag set (R6)
  p_hard_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hard |-> (flag_dck && flag_cerr && flag_rdy));
  // a correctable result always carries a nonzero pattern (R4)
  p_corr_pat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_dck && !flag_hard) |-> (flag_cerr && flag_rdy && err_pat != '0));
endmodule

// File: tb/bec_unit_tb.sv
module bec_unit_tb;
  typedef struct packed {
    logic rdy, dck, cerr, hard;
    logic [15:0] pos;
    logic [10:0] pat;
  } res_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, mode_rd = 0, field_end = 0, in_valid = 0, in_bit = 0, out_ready = 0;
  logic in_ready, out_valid, out_bit, flag_rdy, flag_dck, flag_cerr, flag_hard;
  logic [15:0] err_pos;
  logic [10:0] err_pat;

  bec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_rd(mode_rd), .field_end(field_end),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready), .out_valid(out_valid),
    .out_bit(out_bit), .out_ready(out_ready), .flag_rdy(flag_rdy), .flag_dck(flag_dck),
    .flag_cerr(flag_cerr), .flag_hard(flag_hard), .err_pos(err_pos), .err_pat(err_pat)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit   exp_bits[$];
  res_t exp_res[$];
  bit   cw[0:127];
  logic prev_rdy = 1'b1, hold_pend = 1'b0, held_bit = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      report();
      $finish;
    end
  end

  // monitor: compares against the scoreboard queues
  always @(negedge clk) if (rst_n) begin
    if (hold_pend && out_valid) chk("R9 out_bit held", out_bit, held_bit);
    hold_pend = out_valid && !out_ready;
    held_bit  = out_bit;
    if (out_valid && out_ready) begin
      if (exp_bits.size() == 0) chk("R2 unexpected check bit", 1, 0);
      else chk("R2 check bit", out_bit, exp_bits.pop_front());
    end
    if (flag_rdy && !prev_rdy) begin
      if (exp_res.size() == 0) chk("R3 unexpected result", 1, 0);
      else begin
        res_t e;
        e = exp_res.pop_front();
        chk("R3 R4 R6 flag_rdy", flag_rdy, e.rdy);
        chk("R4 R6 flag_dck", flag_dck, e.dck);
        chk("R4 R6 flag_cerr", flag_cerr, e.cerr);
        chk("R4 R6 flag_hard", flag_hard, e.hard);
        chk("R5 err_pos", err_pos, e.pos);
        chk("R5 err_pat", err_pat, e.pat);
      end
    end
    prev_rdy = flag_rdy;
  end

  function automatic logic [31:0] calc_rem(input int nd);
    logic [31:0] r = '0;
    for (int i = 0; i < nd; i++) begin
      logic fb = cw[i] ^ r[31];
      r = {r[30:0], 1'b0} ^ (fb ? 32'h00A0_0805 : 32'h0);
    end
    return r;
  endfunction

  task automatic fill_data(input int nd, input int seed);
    for (int i = 0; i < nd; i++) cw[i] = (((i * 37 + seed * 11) % 7) > 3);
  endtask

  task automatic pulse_start(input bit rd);
    @(posedge clk); #1 start = 1; mode_rd = rd;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic push_bit(input bit b, input bit gap);
    if (gap) begin in_valid = 0; @(posedge clk); #1; end
    in_valid = 1; in_bit = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic end_field();
    field_end = 1; @(posedge clk); #1 field_end = 0;
  endtask

  task automatic wait_rdy();
    do @(negedge clk); while (!flag_rdy);
    @(posedge clk); #1;
  endtask

  task automatic run_write(input int nd, input int seed, input bit toggle);
    logic [31:0] r;
    fill_data(nd, seed);
    r = calc_rem(nd);
    for (int i = 31; i >= 0; i--) exp_bits.push_back(r[i]);
    exp_res.push_back('{rdy:1, dck:0, cerr:0, hard:0, pos:0, pat:0});
    pulse_start(0);
    for (int i = 0; i < nd; i++) push_bit(cw[i], 1'b0);
    end_field();
    for (int k = 0; !flag_rdy; k++) begin
      out_ready = toggle ? ((k % 3) != 1) : 1'b1;
      @(posedge clk); #1;
    end
    out_ready = 0;
    chk("R2 all 32 bits sent", exp_bits.size(), 0);
  endtask

  // e0..e2: transmission indices to flip, -1 for none
  task automatic run_read(input int nd, input int seed, input int e0, input int e1,
                          input int e2, input bit hard, input bit gaps);
    logic [31:0] r;
    int n = nd + 32, dhi = -1, k;
    int e[3] = '{e0, e1, e2};
    res_t x;
    fill_data(nd, seed);
    r = calc_rem(nd);
    for (int i = 0; i < 32; i++) cw[nd + i] = r[31 - i];
    for (int j = 0; j < 3; j++) if (e[j] >= 0) begin
      cw[e[j]] = ~cw[e[j]];
      if (n - 1 - e[j] > dhi) dhi = n - 1 - e[j];
    end
    x = '{rdy:1, dck:0, cerr:0, hard:0, pos:0, pat:0};
    if (dhi >= 0) begin
      x.dck = 1; x.cerr = 1;
      if (hard) x.hard = 1;
      else begin
        k = (dhi > 10) ? dhi - 10 : 0;
        x.pos = 16'(k);
        for (int j = 0; j < 3; j++)
          if (e[j] >= 0) x.pat[n - 1 - e[j] - k] = 1'b1;
      end
    end
    exp_res.push_back(x);
    pulse_start(1);
    for (int i = 0; i < nd; i++) push_bit(cw[i], gaps && (i % 3 == 0));
    end_field();
    for (int i = 0; i < 32; i++) push_bit(cw[nd + i], gaps && (i % 4 == 0));
    wait_rdy();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 flag_rdy", flag_rdy, 1);
    chk("R1 flag_dck", flag_dck, 0);
    chk("R1 flag_cerr", flag_cerr, 0);
    chk("R1 flag_hard", flag_hard, 0);
    chk("R1 in_ready", in_ready, 0);
    chk("R1 out_valid", out_valid, 0);

    run_write(40, 1, 1'b0);                         // R2
    run_write(33, 2, 1'b1);                         // R2, R9 back-pressure
    run_read(48, 3, -1, -1, -1, 1'b0, 1'b1);        // R3, R9 gaps

    // R7: extra bits after completion are refused and change nothing
    in_valid = 1; in_bit = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 in_ready low", in_ready, 0);
      chk("R7 flags stable", {flag_rdy, flag_dck, flag_cerr, flag_hard}, 4'b1000);
      chk("R7 result stable", {err_pos, err_pat}, 0);
    end
    @(posedge clk); #1 in_valid = 0;

    run_read(48, 4, 10, -1, -1, 1'b0, 1'b0);        // R4 R5 single bit
    run_read(48, 5, 20, 25, 30, 1'b0, 1'b0);        // R4 R5 11-bit burst
    run_read(48, 6, 77, 79, -1, 1'b0, 1'b0);        // R5 clamp at degree 0
    run_read(48, 7, 5, 17, -1, 1'b1, 1'b0);         // R6 hard

    // R8: restart after a hard result clears everything
    pulse_start(1);
    @(negedge clk);
    chk("R8 flag_rdy cleared", flag_rdy, 0);
    chk("R8 flags cleared", {flag_dck, flag_cerr, flag_hard}, 0);
    chk("R8 result cleared", {err_pos, err_pat}, 0);
    prev_rdy = 1'b0;
    run_read(48, 8, -1, -1, -1, 1'b0, 1'b0);        // R3 after restart

    chk("R2 bit queue empty", exp_bits.size(), 0);
    chk("R3 result queue empty", exp_res.size(), 0);
    report();
    $finish;
  end
endmodule